// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, A and B, and moves data between them either live or through storage. Each direction owns a storage register with its own capture strobe: one register keeps bus A data for later delivery to B, and the other keeps bus B data for delivery to A. A per-direction source select picks, for the bus being driven, either the live value on the opposite bus or that direction's stored word. The block can therefore act as a latched transceiver, a pass-through transceiver, or both at once.

An active-low global enable and a direction input decide which bus, if any, is driven. Capture into both registers never depends on the enable or the direction, so the block can isolate both buses and still store data from each. The bus pins appear as separate input, output and output-enable vectors, and the pad logic outside the block forms the tri-state drivers. The capture strobes are plain inputs sampled in the system clock domain. A 0-to-1 change between two consecutive samples counts as a capture event. The `INVERT` parameter builds the variant that drives the bitwise complement of the selected data.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, both storage registers are cleared to zero. Both output-enable vectors are all zeros while `rst` is high.
- R2: The A-side register loads `bus_a_i` at a `clk` edge where `cap_a_stb` is 1 and was 0 at the previous edge. At every other edge the register keeps its value, and this includes edges where the strobe stays high.
- R3: The B-side register loads `bus_b_i` at a `clk` edge where `cap_b_stb` is 1 and was 0 at the previous edge. At every other edge the register keeps its value.
- R4: Capture into both registers works for every value of `out_en_n` and `dir_b`, including the isolated state.
- R5: When `out_en_n` is 1, `bus_a_oe` and `bus_b_oe` are all zeros, and `bus_a_o` and `bus_b_o` are all zeros.
- R6: When `out_en_n` is 0 and `dir_b` is 0, `bus_a_oe` is all ones and `bus_b_oe` is all zeros. At no time are both enable vectors non-zero.
- R7: When `out_en_n` is 0 and `dir_b` is 1, `bus_b_oe` is all ones and `bus_a_oe` is all zeros.
- R8: While bus A is driven, `use_reg_b2a` = 0 sends the current `bus_b_i` to `bus_a_o` in the same cycle, with no register stage. `use_reg_b2a` = 1 sends the B-side register to `bus_a_o`.
- R9: While bus B is driven, `use_reg_a2b` = 0 sends the current `bus_a_i` to `bus_b_o` in the same cycle. `use_reg_a2b` = 1 sends the A-side register to `bus_b_o`.
- R10: With `INVERT` = 1, the driven output is the bitwise complement of the selected live or stored data. With `INVERT` = 0, the data passes unchanged.
- R11: A strobe that is high in the last reset cycle does not trigger a capture. A capture needs the strobe to be seen low after reset and then high.
- R12: A bus that is not driven shows all zeros on its output vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| out_en_n | input | 1 | Global output enable, active low |
| dir_b | input | 1 | 0: drive bus A; 1: drive bus B |
| cap_a_stb | input | 1 | Capture strobe for the A-side register |
| cap_b_stb | input | 1 | Capture strobe for the B-side register |
| use_reg_a2b | input | 1 | Source for bus B: 0 live A, 1 stored A |
| use_reg_b2a | input | 1 | Source for bus A: 0 live B, 1 stored B |
| bus_a_i | input | WIDTH | Value sensed on bus A |
| bus_a_o | output | WIDTH | Value to drive on bus A |
| bus_a_oe | output | WIDTH | Per-bit drive enable for bus A |
| bus_b_i | input | WIDTH | Value sensed on bus B |
| bus_b_o | output | WIDTH | Value to drive on bus B |
| bus_b_oe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The bench builds two copies at the default `WIDTH` of 8, one with `INVERT` = 0 and one with `INVERT` = 1. Both copies see the same stimulus, and the same expected item checks both of them. Running the two variants side by side tests every live and stored path in both polarities. The 8-bit width makes the all-ones and alternating patterns easy to read, and those patterns show any bit swapped between the paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which bus the transceiver is driving this cycle.
   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drive_e;

   function automatic drive_e pick_drive(input logic rst, input logic en_n, input logic to_b);
      if (rst || en_n) return DRV_NONE;
      return to_b ? DRV_B : DRV_A;
   endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   output logic rise
);
   logic seen_q;

   // Reset loads 1, so a strobe held high through reset needs a low sample first.
   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b1;
      else     seen_q <= stb;
   end

   assign rise = stb & ~seen_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_store_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (load) dout <= din;
   end
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             rst,
   input  logic             out_en_n,
   input  logic             dir_b,
   output logic             drv_a,
   output logic             drv_b,
   output logic [WIDTH-1:0] oe_a,
   output logic [WIDTH-1:0] oe_b
);
   drive_e mode;

   always_comb begin
      mode  = pick_drive(rst, out_en_n, dir_b);
      drv_a = (mode == DRV_A);
      drv_b = (mode == DRV_B);
      oe_a  = {WIDTH{drv_a}};
      oe_b  = {WIDTH{drv_b}};
   end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic             drive,
   input  logic             use_reg,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] dout
);
   localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : '0;

   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] shaped;

   assign picked = use_reg ? stored : live;

   generate
      if (INVERT) begin : g_inv
         assign shaped = ~picked;
      end else begin : g_true
         assign shaped = picked ^ FLIP;
      end
   endgenerate

   assign dout = drive ? shaped : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             out_en_n,
   input  logic             dir_b,
   input  logic             cap_a_stb,
   input  logic             cap_b_stb,
   input  logic             use_reg_a2b,
   input  logic             use_reg_b2a,
   input  logic [WIDTH-1:0] bus_a_i,
   output logic [WIDTH-1:0] bus_a_o,
   output logic [WIDTH-1:0] bus_a_oe,
   input  logic [WIDTH-1:0] bus_b_i,
   output logic [WIDTH-1:0] bus_b_o,
   output logic [WIDTH-1:0] bus_b_oe
);
   generate
      if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
         $error("regbus_xcvr: WIDTH out of range");
      end
   endgenerate

   logic             rise_a, rise_b;
   logic             drv_a, drv_b;
   logic [WIDTH-1:0] store_a_q, store_b_q;

   xcvr_strobe_edge u_edge_a (.clk(clk), .rst(rst), .stb(cap_a_stb), .rise(rise_a));
   xcvr_strobe_edge u_edge_b (.clk(clk), .rst(rst), .stb(cap_b_stb), .rise(rise_b));

   xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_a (
      .clk(clk), .rst(rst), .load(rise_a), .din(bus_a_i), .dout(store_a_q));
   xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_b (
      .clk(clk), .rst(rst), .load(rise_b), .din(bus_b_i), .dout(store_b_q));

   xcvr_dir_ctrl #(.WIDTH(WIDTH)) u_dir (
      .rst(rst), .out_en_n(out_en_n), .dir_b(dir_b),
      .drv_a(drv_a), .drv_b(drv_b), .oe_a(bus_a_oe), .oe_b(bus_b_oe));

   // Bus A carries B-side data; bus B carries A-side data.
   xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_a (
      .drive(drv_a), .use_reg(use_reg_b2a), .live(bus_b_i),
      .stored(store_b_q), .dout(bus_a_o));
   xcvr_path_sel #(.WIDTH(WIDTH), .INVERT(INVERT)) u_to_b (
      .drive(drv_b), .use_reg(use_reg_a2b), .live(bus_a_i),
      .stored(store_a_q), .dout(bus_b_o));
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             out_en_n,
   input logic             cap_a_stb,
   input logic             cap_b_stb,
   input logic             use_reg_b2a,
   input logic [WIDTH-1:0] bus_a_i,
   input logic [WIDTH-1:0] bus_b_i,
   input logic [WIDTH-1:0] bus_a_o,
   input logic [WIDTH-1:0] bus_b_o,
   input logic [WIDTH-1:0] bus_a_oe,
   input logic [WIDTH-1:0] bus_b_oe,
   input logic [WIDTH-1:0] store_a,
   input logic [WIDTH-1:0] store_b
);
   localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : '0;

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (store_a == '0 && store_b == '0));

   p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
      $stable(cap_a_stb) |=> $stable(store_a));

   p_load_a_r2: assert property (@(posedge clk) disable iff (rst)
      (cap_a_stb && !$past(cap_a_stb) && !$past(rst)) |=> (store_a == $past(bus_a_i)));

   p_load_b_r3: assert property (@(posedge clk) disable iff (rst)
      (cap_b_stb && !$past(cap_b_stb) && !$past(rst)) |=> (store_b == $past(bus_b_i)));

   p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      out_en_n |-> (bus_a_oe == '0 && bus_b_oe == '0 && bus_a_o == '0 && bus_b_o == '0));

   p_one_side_r6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({|bus_a_oe, |bus_b_oe}));

   p_live_to_a_r8: assert property (@(posedge clk) disable iff (rst)
      (bus_a_oe[0] && !use_reg_b2a) |-> (bus_a_o == (bus_b_i ^ FLIP)));

   p_b_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
      (bus_b_oe == '0) |-> (bus_b_o == '0));
endmodule

bind regbus_xcvr xcvr_checker #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
   .clk(clk), .rst(rst), .out_en_n(out_en_n),
   .cap_a_stb(cap_a_stb), .cap_b_stb(cap_b_stb), .use_reg_b2a(use_reg_b2a),
   .bus_a_i(bus_a_i), .bus_b_i(bus_b_i), .bus_a_o(bus_a_o), .bus_b_o(bus_b_o),
   .bus_a_oe(bus_a_oe), .bus_b_oe(bus_b_oe),
   .store_a(store_a_q), .store_b(store_b_q));

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
   localparam int W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, oen = 1'b1, dir = 1'b0, sa = 1'b0, sb = 1'b0, ua = 1'b0, ub = 1'b0;
   logic [W-1:0] ai = '0, bi = '0;
   logic [W-1:0] ao0, aoe0, bo0, boe0, ao1, aoe1, bo1, boe1;

   regbus_xcvr #(.WIDTH(W), .INVERT(1'b0)) uut (
      .clk(clk), .rst(rst), .out_en_n(oen), .dir_b(dir), .cap_a_stb(sa), .cap_b_stb(sb),
      .use_reg_a2b(ua), .use_reg_b2a(ub), .bus_a_i(ai), .bus_a_o(ao0), .bus_a_oe(aoe0),
      .bus_b_i(bi), .bus_b_o(bo0), .bus_b_oe(boe0));

   regbus_xcvr #(.WIDTH(W), .INVERT(1'b1)) uut_inv (
      .clk(clk), .rst(rst), .out_en_n(oen), .dir_b(dir), .cap_a_stb(sa), .cap_b_stb(sb),
      .use_reg_a2b(ua), .use_reg_b2a(ub), .bus_a_i(ai), .bus_a_o(ao1), .bus_a_oe(aoe1),
      .bus_b_i(bi), .bus_b_o(bo1), .bus_b_oe(boe1));

   typedef struct {
      logic [W-1:0] ao, aoe, bo, boe, ao_n, bo_n;
      string        req;
   } exp_t;

   exp_t sb_q[$];
   int   errors = 0, checks = 0;
   bit   done = 1'b0;

   // Bench model of the stored words and previous strobe samples.
   logic [W-1:0] ma = '0, mb = '0;
   logic pa = 1'b1, pb = 1'b1;

   task automatic cmp(input logic [W-1:0] act, input logic [W-1:0] exp, input string what, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic en_n, input logic d, input logic s_a, input logic s_b,
                       input logic u_a, input logic u_b, input logic [W-1:0] a, input logic [W-1:0] b,
                       input string req);
      exp_t e;
      logic drv_a, drv_b;
      @(negedge clk);
      rst = r; oen = en_n; dir = d; sa = s_a; sb = s_b; ua = u_a; ub = u_b; ai = a; bi = b;
      @(posedge clk);
      if (r) begin
         ma = '0; mb = '0; pa = 1'b1; pb = 1'b1;
      end else begin
         if (s_a && !pa) ma = a;
         if (s_b && !pb) mb = b;
         pa = s_a; pb = s_b;
      end
      #2;
      drv_a = !r && !en_n && !d;
      drv_b = !r && !en_n && d;
      e.aoe  = {W{drv_a}};
      e.boe  = {W{drv_b}};
      e.ao   = drv_a ? (u_b ? mb : b) : '0;
      e.bo   = drv_b ? (u_a ? ma : a) : '0;
      e.ao_n = drv_a ? ~(u_b ? mb : b) : '0;
      e.bo_n = drv_b ? ~(u_a ? ma : a) : '0;
      e.req  = req;
      sb_q.push_back(e);
   endtask

   // Monitor: pops expected items and compares both variants.
   initial begin
      exp_t it;
      forever begin
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         cmp(ao0,  it.ao,   "bus_a_o",  it.req);
         cmp(aoe0, it.aoe,  "bus_a_oe", it.req);
         cmp(bo0,  it.bo,   "bus_b_o",  it.req);
         cmp(boe0, it.boe,  "bus_b_oe", it.req);
         cmp(ao1,  it.ao_n, "inv bus_a_o R10", it.req);
         cmp(aoe1, it.aoe,  "inv bus_a_oe R10", it.req);
         cmp(bo1,  it.bo_n, "inv bus_b_o R10", it.req);
         cmp(boe1, it.boe,  "inv bus_b_oe R10", it.req);
      end
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1 / R11: reset with A strobe held high.
      step(1,0,1,1,1,1,1,8'h5A,8'h66,"R1");
      step(1,0,0,1,1,1,1,8'h5A,8'h66,"R1");
      // R11: strobe still high after reset -> no capture, stored A stays 0 on bus B.
      step(0,0,1,1,1,1,0,8'h5A,8'h66,"R11");
      // R2: strobe low then high captures.
      step(0,0,1,0,0,1,0,8'h11,8'h00,"R2");
      step(0,0,1,1,0,1,0,8'h3C,8'h00,"R2 R9");
      // R2: strobe stays high, no second capture.
      step(0,0,1,1,0,1,0,8'hFF,8'h00,"R2");
      // R9 live path, R7 enables.
      step(0,0,1,0,0,0,0,8'hA5,8'h00,"R9 R7");
      step(0,0,1,0,0,0,0,8'h0F,8'h00,"R9 R12");
      // R8 live path to A, R6 enables.
      step(0,0,0,0,0,0,0,8'h00,8'h81,"R8 R6");
      step(0,0,0,0,0,0,0,8'h00,8'h42,"R8");
      // R4 / R5: isolated, still capturing B.
      step(0,1,0,0,1,0,1,8'h99,8'hC3,"R4 R5 R3");
      step(0,1,1,1,0,1,1,8'h77,8'hEE,"R4 R5 R2");
      // Read back stored words.
      step(0,0,0,0,0,0,1,8'h00,8'h00,"R3 R8 R4");
      step(0,0,1,0,0,1,0,8'h00,8'h00,"R2 R9 R4");
      // R3 hold while strobe stays high.
      step(0,0,0,0,1,0,1,8'h00,8'hAA,"R3");
      step(0,0,0,0,1,0,1,8'h00,8'h55,"R3");
      // Mixed patterns.
      for (int i = 0; i < 40; i++) begin
         step(0, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
              $urandom % 2, $urandom % 2, W'($urandom), W'($urandom), "R6 R7 R8 R9");
      end
      // R1: reset mid-run clears storage.
      step(1,0,0,0,0,0,1,8'h12,8'h34,"R1");
      step(0,0,0,0,0,0,1,8'h12,8'h34,"R1 R8");
      step(0,0,1,0,0,1,0,8'h12,8'h34,"R1 R9");
      #3;
      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule